// File: doc/BRIEF.md
# Timer Counter Byte Access Port

This block is the host-facing register interface for a bank of 16-bit down-counters. The host reaches it over an 8-bit I/O bus with four addresses. Offsets 0, 1 and 2 are the data ports of counters 0, 1 and 2. Offset 3 is a shared control port.

Because each 16-bit count is reached through one 8-bit port, every counter keeps its own byte-order setting (low only, high only, or low then high) and its own write and read byte toggles. The host can freeze a snapshot of a counter with a latch command, or use a read-back command that freezes a status byte, a count, or both, for any subset of counters. When a status byte is pending, it is returned before the count. A minimal counter core sits behind each channel. It takes load strobes and decrements on a shared tick, and it exists only so that the port can be exercised.

The bus is a plain strobe interface, not a stream, and it has no back-pressure. A write or read strobe is accepted on every rising clock edge at which it is high. At most one of the two strobes is high in a given cycle. Read data is valid combinationally during the cycle in which the read strobe is high. The read's side effects (toggle advance, snapshot release) take place at the end of that cycle.

Top module: `tcnt_access_port`

## Requirements
- R1: After reset, each counter is in low-byte-only mode with mode and BCD fields at 0, its count is 0, its null flag is clear, and no snapshot or status is pending. Reads of the data ports return 0x00.
- R2: In low-only mode (control bits 5:4 = 01), a data write of byte b loads the count with 0x00b. In high-only mode (bits 5:4 = 10), it loads 0xb00. Data reads in these modes return the low byte or the high byte, respectively.
- R3: In low-then-high mode (bits 5:4 = 11), the first data write is only staged and leaves the count unchanged. The second data write loads {second byte, first byte}.
- R4: A control write with bits 7:6 = counter number and bits 5:4 not 00 does the following for that counter: it stores bits 5:0, resets the write and read byte toggles, discards any pending snapshot or status, and sets the null flag.
- R5: In low-then-high mode, successive data reads return the low byte and then the high byte.
- R6: A control write with bits 5:4 = 00 latches that counter's count. The snapshot stays fixed while the counter keeps running, until it has been fully read in the current byte order. Further latch requests made before then are ignored.
- R7: A control write with bits 7:6 = 11 is a read-back command. Bit 5 = 0 latches the count and bit 4 = 0 latches the status. Bits 3, 2 and 1 select counters 2, 1 and 0, and several counters may be selected at once.
- R8: The status byte holds the output level in bit 7 (1 when the count is zero), the null flag in bit 6 (set by reprogramming, cleared by the next count load), and the stored control bits in bits 5:0. It is read before any pending count. A second status request made while one is pending is ignored.
- R9: Each counter decrements by one on every cycle in which cnt_tick is high, and it wraps from 0x0000 to 0xFFFF.
- R10: Reading the control offset (3) returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port offset: 0 to 2 are data ports, 3 is the control port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| cnt_tick | input | 1 | Decrement enable shared by all counters |

## Verification
The bench builds the block with its default parameters: three counters of 16 bits each. With these values every data port and every read-back select bit is in use, and a short run of ticks carries a counter across the 0x0000 to 0xFFFF wrap. The scoreboard also sets byte orders and tick counts so that a held snapshot visibly differs from the live count, and it reprograms a counter while a write is only half done.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    RW_LATCH = 2'b00,
    RW_LO    = 2'b01,
    RW_HI    = 2'b10,
    RW_LOHI  = 2'b11
  } rw_mode_e;
endpackage

// File: rtl/tcp_core.sv
module tcp_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             out_lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (tick) cnt <= cnt - CNT_W'(1);
  end

  assign out_lvl = (cnt == '0);

  assert_core_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
  assert_core_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && tick) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));
endmodule

// File: rtl/tcp_ctrl_decode.sv
module tcp_ctrl_decode
  import tcp_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int ADDR_W  = 2
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [NUM_CNT-1:0] prog_stb,
  output logic [NUM_CNT-1:0] cnt_latch_stb,
  output logic [NUM_CNT-1:0] stat_latch_stb,
  output logic [NUM_CNT-1:0] data_wr,
  output logic [NUM_CNT-1:0] data_rd
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CNT);

  logic       ctrl_wr;
  logic [1:0] sel;
  logic       rb;
  rw_mode_e   rw;

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  assign sel     = bus_wdata[7:6];
  assign rb      = (sel == 2'b11);
  assign rw      = rw_mode_e'(bus_wdata[5:4]);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    logic hit;
    assign hit               = ctrl_wr && !rb && (sel == 2'(i));
    assign prog_stb[i]       = hit && (rw != RW_LATCH);
    assign cnt_latch_stb[i]  = (hit && (rw == RW_LATCH)) ||
                               (ctrl_wr && rb && !bus_wdata[5] && bus_wdata[1+i]);
    assign stat_latch_stb[i] = ctrl_wr && rb && !bus_wdata[4] && bus_wdata[1+i];
    assign data_wr[i]        = bus_wr && (bus_addr == ADDR_W'(i));
    assign data_rd[i]        = bus_rd && (bus_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/tcp_chan.sv
module tcp_chan
  import tcp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              prog,
  input  logic              cnt_latch,
  input  logic              stat_latch,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam logic [CTRL_W-1:0] CTRL_RST = {RW_LO, 4'b0000};

  logic [CTRL_W-1:0] ctrl;
  rw_mode_e          rw;
  logic              wr_tog, rd_tog, null_flag;
  logic [BYTE_W-1:0] lo_hold;
  logic              latch_vld, status_vld;
  logic [CNT_W-1:0]  latch_val, src;
  logic [BYTE_W-1:0] status_val, cnt_byte;

  assign rw  = rw_mode_e'(ctrl[5:4]);
  assign src = latch_vld ? latch_val : live_cnt;

  always_comb begin
    case (rw)
      RW_HI:   cnt_byte = src[CNT_W-1:BYTE_W];
      RW_LOHI: cnt_byte = rd_tog ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
      default: cnt_byte = src[BYTE_W-1:0];
    endcase
    rd_byte = status_vld ? status_val : cnt_byte;
  end

  always_comb begin
    ld_stb = data_wr && ((rw == RW_LO) || (rw == RW_HI) || ((rw == RW_LOHI) && wr_tog));
    case (rw)
      RW_HI:   ld_val = {wdata, BYTE_W'(0)};
      RW_LOHI: ld_val = {wdata, lo_hold};
      default: ld_val = {BYTE_W'(0), wdata};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= CTRL_RST;
      wr_tog     <= 1'b0;
      rd_tog     <= 1'b0;
      null_flag  <= 1'b0;
      lo_hold    <= '0;
      latch_vld  <= 1'b0;
      latch_val  <= '0;
      status_vld <= 1'b0;
      status_val <= '0;
    end else if (prog) begin
      ctrl       <= wdata[CTRL_W-1:0];
      wr_tog     <= 1'b0;
      rd_tog     <= 1'b0;
      null_flag  <= 1'b1;
      latch_vld  <= 1'b0;
      status_vld <= 1'b0;
    end else begin
      if (data_wr && (rw == RW_LOHI)) begin
        wr_tog <= !wr_tog;
        if (!wr_tog) lo_hold <= wdata;
      end
      if (ld_stb) null_flag <= 1'b0;
      if (cnt_latch && !latch_vld) begin
        latch_vld <= 1'b1;
        latch_val <= live_cnt;
      end
      if (stat_latch && !status_vld) begin
        status_vld <= 1'b1;
        status_val <= {out_lvl, null_flag, ctrl};
      end
      if (data_rd) begin
        if (status_vld) begin
          status_vld <= 1'b0;
        end else if ((rw == RW_LOHI) && !rd_tog) begin
          rd_tog <= 1'b1;
        end else begin
          rd_tog    <= 1'b0;
          latch_vld <= 1'b0;
        end
      end
    end
  end

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_vld && !data_rd && !prog) |=> (latch_vld && $stable(latch_val)));
  assert_status_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld && data_rd && !prog) |=> !status_vld);
  assert_prog_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (!wr_tog && !rd_tog && null_flag && !latch_vld && !status_vld));
  assert_rd_tog_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tog |-> (rw == RW_LOHI));
  assert_lohi_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (rw == RW_LOHI) && !wr_tog && !prog) |=> wr_tog);
endmodule

// File: rtl/tcnt_access_port.sv
module tcnt_access_port
  import tcp_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       cnt_tick
);
  localparam int ADDR_W = 2;

  logic [NUM_CNT-1:0] prog_stb, cnt_latch_stb, stat_latch_stb, data_wr, data_rd, ld_stb, out_lvl;
  logic [CNT_W-1:0]   ld_val   [NUM_CNT];
  logic [CNT_W-1:0]   live_cnt [NUM_CNT];
  logic [BYTE_W-1:0]  rd_byte  [NUM_CNT];

  tcp_ctrl_decode #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .prog_stb(prog_stb), .cnt_latch_stb(cnt_latch_stb), .stat_latch_stb(stat_latch_stb),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_ch
    tcp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
      .prog(prog_stb[i]), .cnt_latch(cnt_latch_stb[i]), .stat_latch(stat_latch_stb[i]),
      .data_wr(data_wr[i]), .data_rd(data_rd[i]),
      .live_cnt(live_cnt[i]), .out_lvl(out_lvl[i]),
      .ld_stb(ld_stb[i]), .ld_val(ld_val[i]), .rd_byte(rd_byte[i])
    );
    tcp_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .ld(ld_stb[i]), .ld_val(ld_val[i]),
      .tick(cnt_tick), .cnt(live_cnt[i]), .out_lvl(out_lvl[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (bus_addr == ADDR_W'(i)) bus_rdata = rd_byte[i];
  end

  assert_one_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_stb));
  assert_ctrl_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 2'd3)) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/tcnt_access_port_bench.sv
module tcnt_access_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       cnt_tick = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tcnt_access_port u_tcnt_access_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick)
  );

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    @(posedge clk); #1;
    cnt_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 cnt_tick = 1'b0;
  endtask

  // monitor: pops the scoreboard on every read
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state, R10 control offset reads zero
    rd(2'd0, 8'h00, "R1 port0 reset");
    rd(2'd1, 8'h00, "R1 port1 reset");
    rd(2'd2, 8'h00, "R1 port2 reset");
    rd(2'd3, 8'h00, "R10 control read");
    wr(2'd3, 8'hE2);                       // R7 status of counter 0
    rd(2'd0, 8'h90, "R1 reset status");
    rd(2'd0, 8'h00, "R8 status consumed");
    // R2 low-only
    wr(2'd0, 8'h5A);
    rd(2'd0, 8'h5A, "R2 low-only");
    // R2 high-only counter 1, R8 null flag before/after load
    wr(2'd3, 8'h67);
    wr(2'd3, 8'hE4);
    rd(2'd1, 8'hE7, "R8 null set out high");
    wr(2'd1, 8'h3C);
    rd(2'd1, 8'h3C, "R2 high-only");
    wr(2'd3, 8'hE4);
    rd(2'd1, 8'h27, "R8 null cleared");
    // R3 low-then-high counter 2
    wr(2'd3, 8'hB0);
    wr(2'd2, 8'h34);
    wr(2'd3, 8'hD8);
    rd(2'd2, 8'h00, "R3 staged low no load");
    rd(2'd2, 8'h00, "R3 staged high no load");
    wr(2'd2, 8'h12);
    rd(2'd2, 8'h34, "R5 low first");
    rd(2'd2, 8'h12, "R5 high second");
    // R6 latch hold and ignore, R9 decrement
    wr(2'd3, 8'h80);
    tick(5);
    wr(2'd3, 8'h80);
    rd(2'd2, 8'h34, "R6 snapshot low");
    rd(2'd2, 8'h12, "R6 snapshot high");
    rd(2'd2, 8'h2F, "R9 live after ticks");
    rd(2'd2, 8'h12, "R9 live high");
    // R4 reprogram drops snapshot and resets write toggle
    wr(2'd3, 8'h00);
    wr(2'd3, 8'h30);
    rd(2'd0, 8'h55, "R4 snapshot dropped low");
    rd(2'd0, 8'h00, "R4 snapshot dropped high");
    wr(2'd0, 8'h11);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'h22);
    wr(2'd0, 8'h33);
    rd(2'd0, 8'h22, "R4 toggle reset low");
    rd(2'd0, 8'h33, "R4 toggle reset high");
    // R7 multi-counter read-back, R8 status first
    wr(2'd3, 8'hC6);
    rd(2'd0, 8'h30, "R8 status before count c0");
    rd(2'd0, 8'h22, "R7 latched low c0");
    rd(2'd0, 8'h33, "R7 latched high c0");
    rd(2'd1, 8'h27, "R8 status c1");
    rd(2'd1, 8'h3B, "R7 latched high c1");
    // R8 second request ignored while pending
    wr(2'd3, 8'hC8);
    tick(3);
    wr(2'd3, 8'hC8);
    rd(2'd2, 8'h30, "R8 held status");
    rd(2'd2, 8'h2F, "R6 held low");
    rd(2'd2, 8'h12, "R6 held high");
    rd(2'd2, 8'h2C, "R9 live low");
    rd(2'd2, 8'h12, "R9 live high c2");
    // R9 wrap
    wr(2'd3, 8'h10);
    wr(2'd0, 8'h02);
    tick(3);
    rd(2'd0, 8'hFF, "R9 wrap");
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h10, "R8 status low-only");
    rd(2'd0, 8'hFF, "R9 wrap after status");
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule